// File: doc/BRIEF.md
# Radix-4 Digit-Select Inner-Product Unit

This block forms the output of an N-tap transversal filter, the sum over all taps of weight times sample, without any generic multiplier. Each signed L-bit sample is cut into L/2 unsigned two-bit digits. For every weight the block prepares the four multiples 0, w, 2w and 3w once. Each digit then picks one multiple through a 4:1 multiplexer. The pick for the most significant digit is corrected for the sample's sign.

Low-order partial-product bits below a drop point are never formed. Rows of equal digit significance are summed across the taps in one adder tree per digit position. After a register stage, a shift-add tree merges the digit positions. A small set of guard bits is carried between the drop point and the kept output bits. The result is the top OUT_BITS bits of the full-precision sum, truncated toward minus infinity, and it is registered. The taps' weights and delayed samples come from outside. Error forming and weight adaptation live in neighbouring blocks.

Top module: `r4_inner_product`

## Requirements
- R1: With defaults (4 taps, 8-bit signed weights and samples, drop point 6, 8 output bits), y_o equals bits 11..4 of T. T is the sum over taps t and digits k = 0..3 of floor(w_t·d_tk·4^k / 64), minus 4·w_t for every tap whose sample is negative. Here d_tk is bits 2k+1..2k of the sample taken as unsigned.
- R2: A digit of value 0, 1, 2 or 3 selects 0, w, 2w or 3w respectively for its weight.
- R3: Partial-product bits of weight below 2^6 are discarded before summation. For w = 127 and x = 63 on all taps the output is 30, while the exact product sum would give 31.
- R4: A new input set appears on y_o exactly two rising clock edges after it is applied. y_o holds its value while the registered digit sums are unchanged, and all-zero weights yield a zero output.
- R5: Negative samples, including -128, are handled through the sign correction on the top digit. -128 × -128 on all taps gives 64, and -128 × 127 on all taps gives 0xC0.
- R6: While rst_ni is low, y_o is 0 whatever the inputs.
- R7: The guard bits are dropped by truncation, not rounding. Weight 1 and sample -1 on all taps give 0xFF.
- R8: Input sets may change on every clock cycle, and the outputs follow one per cycle in the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| weight_i | input | N_TAPS*W_BITS | Signed weights, tap t in bits t*W_BITS upward |
| sample_i | input | N_TAPS*L_BITS | Signed tap samples, tap t in bits t*L_BITS upward |
| y_o | output | OUT_BITS | Truncated inner product |

## Verification
Every result is due two rising edges after its input set is driven. The first edge registers the per-digit sums and the second registers the merged output. The bench drives inputs on the falling edge and reads y_o on the falling edge that follows the second rising edge. The latency scenario also reads after one edge, to confirm that the previous result is still present. The streaming scenario changes inputs every cycle and compares each output against the set driven two falling edges earlier.

// File: rtl/r4ip_pkg.sv
`timescale 1ns/1ps
package r4ip_pkg;
  // right shift applied to digit row k before the adder tree
  function automatic int row_rshift(input int k, input int drop);
    return (drop > 2 * k) ? drop - 2 * k : 0;
  endfunction
  // left shift applied to digit row k in the shift-add tree
  function automatic int row_lshift(input int k, input int drop);
    return (2 * k > drop) ? 2 * k - drop : 0;
  endfunction
endpackage

// File: rtl/r4ip_multiples.sv
`timescale 1ns/1ps
module r4ip_multiples #(
  parameter int W_BITS = 8
) (
  input  logic [W_BITS-1:0]          w_i,
  output logic [3:0][W_BITS+1:0]     mult_o
);
  logic [W_BITS+1:0] w1, w2;
  assign w1 = {{2{w_i[W_BITS-1]}}, w_i};
  assign w2 = {w_i[W_BITS-1], w_i, 1'b0};
  assign mult_o[0] = '0;
  assign mult_o[1] = w1;
  assign mult_o[2] = w2;
  assign mult_o[3] = w1 + w2;
endmodule

// File: rtl/r4ip_digit_sel.sv
`timescale 1ns/1ps
module r4ip_digit_sel #(
  parameter int W_BITS    = 8,
  parameter int DROP_BITS = 6,
  parameter int DIGIT     = 0,
  parameter bit TOP       = 1'b0,
  localparam int RW       = W_BITS + 3,
  localparam int RSH      = r4ip_pkg::row_rshift(DIGIT, DROP_BITS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [3:0][W_BITS+1:0]     mult_i,
  input  logic [W_BITS-1:0]          w_i,
  input  logic [1:0]                 digit_i,
  input  logic                       sign_i,
  output logic [RW-1:0]              row_o
);
  logic [W_BITS+1:0] pp;
  logic [RW-1:0]     pp_x, corr, val;

  assign pp   = mult_i[digit_i];
  assign pp_x = {pp[W_BITS+1], pp};
  // top digit: remove sign weight 2^L, i.e. 4w in top-row units
  assign corr = (TOP && sign_i) ? {w_i[W_BITS-1], w_i, 2'b00} : '0;
  assign val  = pp_x - corr;

  generate
    if (RSH > 0) begin : g_trunc
      assign row_o = {{RSH{val[RW-1]}}, val[RW-1:RSH]};
    end else begin : g_full
      assign row_o = val;
    end
  endgenerate

  a_r2_sel_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_i == 2'd0) |-> (pp == '0));
  a_r2_sel_three: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_i == 2'd3) |-> ($signed(pp) == 3 * $signed(w_i)));
endmodule

// File: rtl/r4ip_row_tree.sv
`timescale 1ns/1ps
module r4ip_row_tree #(
  parameter int N_TAPS = 4,
  parameter int RW     = 11,
  localparam int LV    = $clog2(N_TAPS),
  localparam int SW    = RW + LV,
  localparam int NP    = 1 << LV
) (
  input  logic [N_TAPS-1:0][RW-1:0] rows_i,
  output logic [SW-1:0]             sum_o
);
  // heap layout: node j (1-based) stored at index j-1, leaves at NP..2NP-1
  logic [SW-1:0] node [2*NP-1];

  generate
    for (genvar i = 0; i < NP; i++) begin : g_leaf
      if (i < N_TAPS) begin : g_use
        assign node[NP-1+i] = {{LV{rows_i[i][RW-1]}}, rows_i[i]};
      end else begin : g_pad
        assign node[NP-1+i] = '0;
      end
    end
    for (genvar j = 1; j < NP; j++) begin : g_add
      assign node[j-1] = node[2*j-1] + node[2*j];
    end
  endgenerate

  assign sum_o = node[0];
endmodule

// File: rtl/r4_inner_product.sv
`timescale 1ns/1ps
module r4_inner_product #(
  parameter int N_TAPS    = 4,
  parameter int W_BITS    = 8,
  parameter int L_BITS    = 8,
  parameter int DROP_BITS = 6,
  parameter int OUT_BITS  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_TAPS*W_BITS-1:0]   weight_i,
  input  logic [N_TAPS*L_BITS-1:0]   sample_i,
  output logic [OUT_BITS-1:0]        y_o
);
  localparam int DIGITS = L_BITS / 2;
  localparam int RW     = W_BITS + 3;
  localparam int SW     = RW + $clog2(N_TAPS);
  localparam int FULL_W = W_BITS + L_BITS + $clog2(N_TAPS);
  localparam int TW     = FULL_W - DROP_BITS;
  localparam int GUARD  = TW - OUT_BITS;
  localparam int ACC_W  = SW + 2 * DIGITS;

  logic [DIGITS-1:0][N_TAPS-1:0][RW-1:0] rows;
  logic [DIGITS-1:0][SW-1:0]             row_d, row_q;
  logic [ACC_W-1:0]                      acc;

  generate
    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
      logic [3:0][W_BITS+1:0] mult;
      r4ip_multiples #(.W_BITS(W_BITS)) u_mult (
        .w_i    (weight_i[t*W_BITS +: W_BITS]),
        .mult_o (mult)
      );
      for (genvar k = 0; k < DIGITS; k++) begin : g_dig
        r4ip_digit_sel #(
          .W_BITS(W_BITS), .DROP_BITS(DROP_BITS), .DIGIT(k), .TOP(k == DIGITS - 1)
        ) u_sel (
          .clk_i   (clk_i),
          .rst_ni  (rst_ni),
          .mult_i  (mult),
          .w_i     (weight_i[t*W_BITS +: W_BITS]),
          .digit_i (sample_i[t*L_BITS + 2*k +: 2]),
          .sign_i  (sample_i[t*L_BITS + L_BITS - 1]),
          .row_o   (rows[k][t])
        );
      end
    end
    for (genvar k = 0; k < DIGITS; k++) begin : g_tree
      r4ip_row_tree #(.N_TAPS(N_TAPS), .RW(RW)) u_tree (
        .rows_i (rows[k]),
        .sum_o  (row_d[k])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= '0;
    else         row_q <= row_d;
  end

  // shift-add tree across digit positions
  always_comb begin
    acc = '0;
    for (int k = 0; k < DIGITS; k++) begin
      acc = acc + ({{(ACC_W-SW){row_q[k][SW-1]}}, row_q[k]}
                   << r4ip_pkg::row_lshift(k, DROP_BITS));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_o <= '0;
    else         y_o <= acc[GUARD +: OUT_BITS];
  end

  a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc[ACC_W-1:TW-1] == '0) || (acc[ACC_W-1:TW-1] == '1));
  a_r4_zero_weights: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (weight_i == '0) |=> ##1 (y_o == '0));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(row_q) |=> $stable(y_o));
  a_r6_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (y_o == '0));
endmodule

// File: tb/r4_inner_product_tb.sv
`timescale 1ns/1ps
module r4_inner_product_tb;
  localparam int NT = 4;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [31:0]   weight_i = '0;
  logic [31:0]   sample_i = '0;
  logic [7:0]    y_o;
  int n_chk = 0;
  int n_err = 0;
  int wv[NT];
  int xv[NT];

  always #10 clk_i = ~clk_i;

  r4_inner_product u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .weight_i(weight_i), .sample_i(sample_i), .y_o(y_o)
  );

  // requirement R1 formula, computed with plain arithmetic
  function automatic logic [7:0] model();
    int s = 0;
    for (int t = 0; t < NT; t++) begin
      int xu = xv[t] & 255;
      for (int k = 0; k < 4; k++) begin
        int d = (xu >> (2 * k)) & 3;
        int p = wv[t] * d;
        if (2 * k < 6) s += (p <<< (2 * k)) >>> 6;
        else           s += p <<< (2 * k - 6);
      end
      if (xv[t] < 0) s -= 4 * wv[t];
    end
    return 8'((s >>> 4) & 255);
  endfunction

  task automatic drive();
    for (int t = 0; t < NT; t++) begin
      weight_i[t*8 +: 8] = 8'(wv[t]);
      sample_i[t*8 +: 8] = 8'(xv[t]);
    end
  endtask

  task automatic set_all(input int w, input int x);
    for (int t = 0; t < NT; t++) begin
      wv[t] = w;
      xv[t] = x;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // drive at falling edge, read after two rising edges
  task automatic run_check(input string tag, input logic [7:0] exp);
    @(negedge clk_i);
    drive();
    @(negedge clk_i);
    @(negedge clk_i);
    chk(tag, y_o, exp);
  endtask

  task automatic t_reset();
    set_all(100, -77);
    @(negedge clk_i);
    drive();
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R6 reset holds output", y_o, 8'h00);
    rst_ni = 1'b1;
    set_all(0, 0);
    run_check("R4 zero weights", 8'h00);
  endtask

  task automatic t_select();
    set_all(0, 0);
    wv[0] = 64;
    xv[0] = 8'h40;
    run_check("R2 digit=1 selects w", 8'd4);
    xv[0] = 8'h2A;
    run_check("R2 digits 2,2,2 select 2w", model());
    xv[0] = 8'h3F;
    run_check("R2 digits 3 select 3w", model());
    wv[1] = -50;
    xv[1] = 8'h33;
    run_check("R2 mixed digits two taps", model());
  endtask

  task automatic t_truncation();
    set_all(127, 63);
    run_check("R3 dropped low bits (exact would be 31)", 8'd30);
    set_all(1, 3);
    run_check("R3 small products vanish", 8'd0);
  endtask

  task automatic t_sign();
    set_all(-128, -128);
    run_check("R5 -128 x -128", 8'd64);
    set_all(-128, 127);
    run_check("R5 -128 x 127", 8'hC0);
    set_all(90, -100);
    run_check("R5 negative sample", model());
  endtask

  task automatic t_floor();
    set_all(1, -1);
    run_check("R7 truncation toward minus infinity", 8'hFF);
  endtask

  task automatic t_latency();
    logic [7:0] old_v, new_v;
    set_all(127, 127);
    run_check("R4 settle first set", model());
    old_v = model();
    set_all(-128, 127);
    new_v = model();
    @(negedge clk_i);
    drive();
    @(negedge clk_i);
    chk("R4 one edge: previous result held", y_o, old_v);
    @(negedge clk_i);
    chk("R4 two edges: new result", y_o, new_v);
    @(negedge clk_i);
    chk("R4 output holds with steady inputs", y_o, new_v);
  endtask

  task automatic t_stream();
    logic [7:0] exp_q[$];
    int seed = 12345;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk_i);
      if (exp_q.size() >= 2) chk("R8 streamed output", y_o, exp_q.pop_front());
      for (int t = 0; t < NT; t++) begin
        seed = seed * 1103515245 + 12345;
        wv[t] = ((seed >>> 8) & 255) - 128;
        seed = seed * 1103515245 + 12345;
        xv[t] = ((seed >>> 8) & 255) - 128;
      end
      drive();
      exp_q.push_back(model());
    end
    @(negedge clk_i);
    chk("R8 streamed output", y_o, exp_q.pop_front());
    @(negedge clk_i);
    chk("R1 last streamed output", y_o, exp_q.pop_front());
  endtask

  initial begin
    t_reset();
    t_select();
    t_truncation();
    t_sign();
    t_floor();
    t_latency();
    t_stream();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule